// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Tags

This block is the receive half of an asynchronous serial port. It runs the incoming line through a two-stage synchronizer and samples it at sixteen times the bit rate. The rate comes from a programmable divisor on the system clock. Each frame carries eight data bits, least significant bit first. The frame may also carry an even parity bit, and it ends with one or two stop bits.

Every received character is written into a receive queue of `FIFO_DEPTH` entries. Each entry keeps four error flags that belong to that character alone. A consumer pulses `rd_en` and picks up a 16-bit word on the next cycle. The data byte sits in the low byte of that word and the error flags sit in the top nibble. The host can therefore see which character was damaged, and how. The host also gets queue status outputs and a flush input that discards everything queued.

Top module: `uart_rx_tagged`

## Requirements
- R1: One bit time is 16 × `divisor` clock cycles. A divisor of 0 or 1 behaves as 2. Characters sent at the set rate arrive intact for divisors 2 and 3.
- R2: Data bits are taken least significant first. The character appears in `rd_word[7:0]`, and `rd_word[11:8]` always reads zero.
- R3: When `parity_en` is 1, the bit after the data is checked for even parity (data plus parity bit holds an even count of ones). A mismatch sets `rd_word[13]`. A match leaves it clear.
- R4: A low level at the first stop-bit position sets the framing flag `rd_word[14]`.
- R5: When all data bits, the parity bit (if enabled) and the first stop bit are low, the entry is a break. `rd_word[15]` is set, and `rd_word[14]` is also set.
- R6: When `two_stop` is 1, the receiver ignores the line during the second stop bit. A low level there neither starts a character nor flags an error.
- R7: Entries leave the queue in arrival order. `fifo_half` is 1 when at least `FIFO_DEPTH`/2 entries are held. `fifo_full` is 1 at `FIFO_DEPTH` entries.
- R8: A character that completes while the queue is full is dropped. The next character that is stored carries the overrun flag `rd_word[12]`. Entries stored before the drop do not carry it.
- R9: A one-cycle `flush` pulse empties the queue. The status outputs show empty on the next cycle.
- R10: After reset, `fifo_empty`=1, `fifo_full`=0, `fifo_half`=0, `rx_ready`=0 and `rd_word`=0.
- R11: `rx_ready` is 1 exactly when the queue holds an entry. A `rd_en` pulse on a non-empty queue places the oldest entry on `rd_word` in the following cycle.
- R12: A low pulse shorter than half a bit time is rejected at the start-bit mid-point and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 10 | Clock cycles per oversample tick |
| parity_en | input | 1 | Expect an even parity bit after the data |
| two_stop | input | 1 | Frames carry two stop bits |
| rx_in | input | 1 | Serial line, idle high |
| flush | input | 1 | Discard every queued entry |
| rd_en | input | 1 | Pop the oldest entry |
| rd_word | output | 16 | Popped entry: flags in [15:12], data in [7:0] |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| fifo_half | output | 1 | Queue at least half full |
| rx_ready | output | 1 | At least one entry waiting |

## Verification
A table of frames is played at one divisor. It covers a clean byte, parity good and bad, a low first stop bit, and all-zero frames with and without parity. These cases separate the parity, framing and break flags from one another, and from the data byte. A second divisor and alternating or single-bit data patterns expose bit-order and timing faults. Filling the queue to its depth and past it shows the half and full thresholds, checks that order is kept, and confirms that the overrun tag lands on the next stored entry and on no earlier one. Directed cases cover a short glitch, the ignored second stop bit, flush and the reset state.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic              ovr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP1,
    RX_STOP2
  } rx_state_t;

endpackage

// File: rtl/uart_rx_baudgen.sv
module uart_rx_baudgen #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] last;

  always_comb begin
    div_eff = (divisor < MIN_DIV) ? MIN_DIV : divisor;
    last    = div_eff - DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R1

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              parity_en,
  input  logic              two_stop,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_brk,
  output logic              out_frm,
  output logic              out_par
);
  localparam int OSR_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [OSR_W-1:0] MID_CNT  = OSR_W'(OSR / 2 - 1);
  localparam logic [OSR_W-1:0] LAST_CNT = OSR_W'(OSR - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rx_state_t         state;
  logic [OSR_W-1:0]  os_cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              stop1_q;
  logic              centre;

  always_comb centre = tick && (os_cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      os_cnt    <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      par_bit   <= 1'b0;
      stop1_q   <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_brk   <= 1'b0;
      out_frm   <= 1'b0;
      out_par   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (tick && !centre && state != RX_IDLE && state != RX_START)
        os_cnt <= os_cnt + OSR_W'(1);
      unique case (state)
        RX_IDLE: begin
          if (tick && !rx_s) begin
            state  <= RX_START;
            os_cnt <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (os_cnt == MID_CNT) begin
              os_cnt  <= '0;
              bit_idx <= '0;
              state   <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              os_cnt <= os_cnt + OSR_W'(1);
            end
          end
        end
        RX_DATA: begin
          if (centre) begin
            os_cnt  <= '0;
            shreg   <= {rx_s, shreg[DATA_W-1:1]};
            bit_idx <= bit_idx + BIT_W'(1);
            if (bit_idx == LAST_BIT)
              state <= parity_en ? RX_PARITY : RX_STOP1;
          end
        end
        RX_PARITY: begin
          if (centre) begin
            os_cnt  <= '0;
            par_bit <= rx_s;
            state   <= RX_STOP1;
          end
        end
        RX_STOP1: begin
          if (centre) begin
            os_cnt  <= '0;
            stop1_q <= rx_s;
            if (two_stop) begin
              state <= RX_STOP2;
            end else begin
              state     <= RX_IDLE;
              out_valid <= 1'b1;
              out_data  <= shreg;
              out_frm   <= !rx_s;
              out_par   <= parity_en && (par_bit != ^shreg);
              out_brk   <= (shreg == '0) && !rx_s && !(parity_en && par_bit);
            end
          end
        end
        RX_STOP2: begin
          if (centre) begin
            os_cnt    <= '0;
            state     <= RX_IDLE;
            out_valid <= 1'b1;
            out_data  <= shreg;
            out_frm   <= !stop1_q;
            out_par   <= parity_en && (par_bit != ^shreg);
            out_brk   <= (shreg == '0) && !stop1_q && !(parity_en && par_bit);
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  AST_CHAR_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(tick)); // R1
  AST_CHAR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R2
  AST_BREAK_IMPLIES_FRAME: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_brk) |-> (out_frm && out_data == '0)); // R5

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic             half
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count, count_nxt;
  logic             push_ok, pop_ok;

  always_comb begin
    push_ok   = push && !full;
    pop_ok    = pop && !empty;
    count_nxt = count;
    if (flush)
      count_nxt = '0;
    else if (push_ok && !pop_ok)
      count_nxt = count + CW'(1);
    else if (pop_ok && !push_ok)
      count_nxt = count - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush)
      mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (pop_ok && !flush)
      rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
      half  <= 1'b0;
    end else begin
      if (flush) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (push_ok) wptr <= wptr + AW'(1);
        if (pop_ok)  rptr <= rptr + AW'(1);
      end
      count <= count_nxt;
      empty <= (count_nxt == '0);
      full  <= (count_nxt == DEPTH_C);
      half  <= (count_nxt >= HALF_C);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C); // R7
  AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    !(empty && full)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && !half)); // R9
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && !pop && !flush) |=> full); // R8

endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
  import uart_rx_pkg::*;
#(
  parameter int DIV_W      = 10,
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              parity_en,
  input  logic              two_stop,
  input  logic              rx_in,
  input  logic              flush,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              fifo_half,
  output logic              rx_ready
);
  localparam int ENTRY_W = $bits(rx_entry_t);
  localparam int GAP_W   = WORD_W - 4 - CHAR_W;

  logic [1:0]        sync_q;
  logic              tick;
  logic              ch_valid;
  logic [CHAR_W-1:0] ch_data;
  logic              ch_brk, ch_frm, ch_par;
  logic              ovr_pend;
  rx_entry_t         wr_entry, rd_entry;
  logic [ENTRY_W-1:0] rd_raw;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rx_in};
  end

  uart_rx_baudgen #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .divisor (divisor),
    .tick    (tick)
  );

  uart_rx_framer #(.OSR(OSR), .DATA_W(CHAR_W)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .rx_s      (sync_q[1]),
    .parity_en (parity_en),
    .two_stop  (two_stop),
    .out_valid (ch_valid),
    .out_data  (ch_data),
    .out_brk   (ch_brk),
    .out_frm   (ch_frm),
    .out_par   (ch_par)
  );

  always_ff @(posedge clk) begin
    if (rst || flush)
      ovr_pend <= 1'b0;
    else if (ch_valid)
      ovr_pend <= fifo_full;
  end

  always_comb begin
    wr_entry.brk  = ch_brk;
    wr_entry.frm  = ch_frm;
    wr_entry.par  = ch_par;
    wr_entry.ovr  = ovr_pend;
    wr_entry.data = ch_data;
  end

  uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (ch_valid),
    .wdata (wr_entry),
    .pop   (rd_en),
    .rdata (rd_raw),
    .empty (fifo_empty),
    .full  (fifo_full),
    .half  (fifo_half)
  );

  always_comb begin
    rd_entry = rx_entry_t'(rd_raw);
    rd_word  = {rd_entry.brk, rd_entry.frm, rd_entry.par, rd_entry.ovr,
                {GAP_W{1'b0}}, rd_entry.data};
    rx_ready = !fifo_empty;
  end

  AST_DROP_SETS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && fifo_full && !flush) |=> ovr_pend); // R8
  AST_READY_AFTER_STORE: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && !fifo_full && !flush) |=> rx_ready); // R11

endmodule

// File: tb/tb_uart_rx_tagged.sv
module tb_uart_rx_tagged;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  divisor = 10'd3;
  logic        parity_en = 1'b0;
  logic        two_stop = 1'b0;
  logic        rx_in = 1'b1;
  logic        flush = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_word;
  logic        fifo_empty, fifo_full, fifo_half, rx_ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  uart_rx_tagged dut (
    .clk(clk), .rst(rst), .divisor(divisor), .parity_en(parity_en),
    .two_stop(two_stop), .rx_in(rx_in), .flush(flush), .rd_en(rd_en),
    .rd_word(rd_word), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_half(fifo_half), .rx_ready(rx_ready)
  );

  // {parity_en, bad_parity, stop_low, data[7:0], expected word[15:0]}
  localparam logic [26:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 8'h55, 16'h0055},
    {1'b1, 1'b0, 1'b0, 8'hA3, 16'h00A3},
    {1'b1, 1'b1, 1'b0, 8'hA3, 16'h20A3},
    {1'b0, 1'b0, 1'b1, 8'h0F, 16'h400F},
    {1'b0, 1'b0, 1'b1, 8'h00, 16'hC000},
    {1'b1, 1'b0, 1'b1, 8'h00, 16'hC000},
    {1'b1, 1'b0, 1'b0, 8'h80, 16'h0080},
    {1'b0, 1'b0, 1'b0, 8'hFF, 16'h00FF}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_in = b;
    repeat (16 * int'(divisor)) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit pe, input bit badp, input bit stop_low);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (pe) drive_bit((^d) ^ badp);
    drive_bit(!stop_low);
    drive_bit(1'b1);
    drive_bit(1'b1);
  endtask

  task automatic pop(output logic [15:0] w);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    w = rd_word;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 empty", 16'(fifo_empty), 16'd1);
    chk("R10 full/half/ready", {13'd0, fifo_full, fifo_half, rx_ready}, 16'd0);
    chk("R10 rd_word", rd_word, 16'h0000);

    // Vector table at divisor 3: R1 R2 R3 R4 R5 R11
    divisor = 10'd3;
    for (int v = 0; v < 8; v++) begin
      parity_en = VEC[v][26];
      send(VEC[v][23:16], VEC[v][26], VEC[v][25], VEC[v][24]);
      chk("R11 ready before pop", 16'(rx_ready), 16'd1);
      pop(w);
      chk("R1/R2/R3/R4/R5 table word", w, VEC[v][15:0]);
      chk("R11 empty after single pop", 16'(fifo_empty), 16'd1);
    end
    parity_en = 1'b0;

    // R12 short glitch rejected
    rx_in = 1'b0;
    repeat (4 * 3) @(negedge clk);
    rx_in = 1'b1;
    repeat (3 * 48) @(negedge clk);
    chk("R12 glitch stores nothing", 16'(fifo_empty), 16'd1);

    // R6 second stop bit ignored
    two_stop = 1'b1;
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(logic'((8'h3C >> i) & 1));
    drive_bit(1'b1);
    drive_bit(1'b0);
    drive_bit(1'b1);
    drive_bit(1'b1);
    drive_bit(1'b1);
    two_stop = 1'b0;
    pop(w);
    chk("R6 two-stop word clean", w, 16'h003C);
    chk("R6 nothing from low second stop", 16'(fifo_empty), 16'd1);

    // Fill at divisor 2: R1 R7 R8
    divisor = 10'd2;
    for (int i = 0; i < 64; i++) begin
      send(8'(i), 1'b0, 1'b0, 1'b0);
      if (i == 30) chk("R7 half clear at 31", 16'(fifo_half), 16'd0);
      if (i == 31) chk("R7 half set at 32", 16'(fifo_half), 16'd1);
      if (i == 62) chk("R7 not full at 63", 16'(fifo_full), 16'd0);
    end
    chk("R7 full at depth", 16'(fifo_full), 16'd1);
    send(8'hEE, 1'b0, 1'b0, 1'b0);
    chk("R8 still full after drop", 16'(fifo_full), 16'd1);
    pop(w);
    chk("R8 first entry untagged", w, 16'h0000);
    send(8'h77, 1'b0, 1'b0, 1'b0);
    chk("R8 full again", 16'(fifo_full), 16'd1);
    begin
      int bad = 0;
      for (int i = 1; i < 64; i++) begin
        pop(w);
        if (w !== 16'(i)) begin
          bad++;
          $display("FAIL R7 order actual=%h expected=%h", w, 16'(i));
        end
      end
      checks++;
      if (bad != 0) fails++;
    end
    pop(w);
    chk("R8 overrun tag on next stored", w, 16'h1077);
    chk("R7 empty after drain", 16'(fifo_empty), 16'd1);

    // R9 flush
    divisor = 10'd3;
    for (int i = 0; i < 3; i++) send(8'hA0 + 8'(i), 1'b0, 1'b0, 1'b0);
    chk("R11 ready with entries", 16'(rx_ready), 16'd1);
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
    chk("R9 empty after flush", {14'd0, fifo_empty, rx_ready}, 16'h0002);
    send(8'h5A, 1'b0, 1'b0, 1'b0);
    pop(w);
    chk("R9 fresh entry after flush", w, 16'h005A);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule